// File: doc/BRIEF.md
# Mailbox channel state interrupt generator

This block sits beside the shared RAM of a coprocessor and watches byte writes arriving from two sides: the coprocessor's own port and the host's port. The RAM holds a mailbox with seven outbound (host to coprocessor) channels and seven inbound (coprocessor to host) channels. Each channel has a single 32-byte message slot and a one-byte state. The block keeps a shadow copy of every state byte. From those copies it derives two channel bitmaps and two sticky host interrupt flags. Message payload bytes pass by untouched.

The outbound interrupt flag (`int0_o`) is raised when the coprocessor marks an outbound channel finished. The inbound flag (`int1_o`) is raised when the coprocessor posts a new inbound message. A raised flag stays up until the host clears it through a strobe. The block also shadows a liveness byte. The coprocessor sets this byte to 0xFF to show that it runs, and the host zeroes it after reading it.

State bytes use these codes: 0 is idle, 1 is new, 2 is received and 3 is complete.

Top module: `mbx_state_irq`

## Requirements
- R1: After reset, every shadowed state byte is 0 (idle). Both bitmaps are all zero, `int0_o` and `int1_o` are low, and `alive_o` is low.
- R2: A write from either port to address TX_STATE_BASE+n (n = 0..6) replaces the shadow of outbound state n with the written byte, on the same clock edge. Bit n of `tx_done_map_o` is 1 exactly when that byte equals 3 (complete).
- R3: A write from either port to address RX_STATE_BASE+n (n = 0..6) replaces the shadow of inbound state n. Bit n of `rx_new_map_o` is 1 exactly when that byte equals 1 (new).
- R4: A coprocessor write of 3 to any outbound state byte sets `int0_o`, starting in the cycle after the write edge.
- R5: A coprocessor write of 1 to any inbound state byte sets `int1_o`, starting in the cycle after the write edge.
- R6: Host writes to state bytes never set either flag, whatever value they carry. They still update the bitmaps as stated in R2 and R3.
- R7: A set flag stays set, whatever further state writes arrive, until its clear strobe (`int0_clr_i` or `int1_clr_i`) is sampled high. If a set and a clear of the same flag fall in the same cycle, the flag ends up set.
- R8: `alive_o` is high exactly when the shadowed liveness byte at ALIVE_ADDR equals 0xFF. Writes from either port replace that byte.
- R9: When both ports write the same state or liveness byte in the same cycle, the coprocessor's value is kept.
- R10: Writes to any other address change nothing. This includes message slots (area base + n*32) and the unused eighth position after each state array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cp_we_i | input | 1 | Coprocessor RAM write strobe |
| cp_addr_i | input | 16 | Coprocessor write address |
| cp_wdata_i | input | 8 | Coprocessor write data |
| host_we_i | input | 1 | Host RAM write strobe |
| host_addr_i | input | 16 | Host write address |
| host_wdata_i | input | 8 | Host write data |
| int0_clr_i | input | 1 | Clears the outbound-complete flag |
| int1_clr_i | input | 1 | Clears the inbound-new flag |
| int0_o | output | 1 | Outbound-complete interrupt flag |
| int1_o | output | 1 | Inbound-new interrupt flag |
| tx_done_map_o | output | 7 | Outbound channels whose state is complete |
| rx_new_map_o | output | 7 | Inbound channels whose state is new |
| alive_o | output | 1 | Liveness byte equals 0xFF |

## Verification
The bench builds the block with its default parameters: seven channels per direction, state arrays at 0x0300 and 0x0308, and the liveness byte at 0x0310. With these values it can sweep every channel, including the unused eighth slot, against all four state codes from both ports. The flags are cleared between sweep steps, so every set is seen on its own. Directed sequences then cover sticky flags, a clear that collides with a set, same-byte port collisions, message-slot writes and the liveness byte.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int AW = 16;

  typedef enum logic [7:0] {
    ST_IDLE     = 8'h00,
    ST_NEW      = 8'h01,
    ST_RCVD     = 8'h02,
    ST_COMPLETE = 8'h03
  } ch_state_e;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [7:0]    data;
  } snoop_t;
endpackage

// File: rtl/mbx_chan_tracker.sv
module mbx_chan_tracker
  import mbx_pkg::*;
#(
  parameter int            N_CHAN = 7,
  parameter logic [AW-1:0] BASE   = '0,
  parameter logic [7:0]    MATCH  = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  snoop_t            cp_i,
  input  snoop_t            host_i,
  output logic [N_CHAN-1:0] map_o,
  output logic              hit_o
);
  logic [N_CHAN-1:0] cp_set;

  for (genvar g = 0; g < N_CHAN; g++) begin : g_ch
    localparam logic [AW-1:0] ChAddr = BASE + AW'(g);
    logic       cp_sel, host_sel;
    logic [7:0] st_q;

    assign cp_sel   = cp_i.we   && (cp_i.addr   == ChAddr);
    assign host_sel = host_i.we && (host_i.addr == ChAddr);

    // coprocessor port wins a same-byte collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q <= ST_IDLE;
      else if (cp_sel)   st_q <= cp_i.data;
      else if (host_sel) st_q <= host_i.data;
    end

    assign map_o[g]  = (st_q == MATCH);
    assign cp_set[g] = cp_sel && (cp_i.data == MATCH);
  end

  assign hit_o = |cp_set;
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set has priority so an event is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= 1'b0;
    else         flag_o <= set_i | (flag_o & ~clr_i);
  end
endmodule

// File: rtl/mbx_alive.sv
module mbx_alive
  import mbx_pkg::*;
#(
  parameter logic [AW-1:0] ADDR = '0
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  snoop_t cp_i,
  input  snoop_t host_i,
  output logic   alive_o
);
  logic [7:0] alive_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  alive_q <= 8'h00;
    else if (cp_i.we && cp_i.addr == ADDR)        alive_q <= cp_i.data;
    else if (host_i.we && host_i.addr == ADDR)    alive_q <= host_i.data;
  end

  assign alive_o = (alive_q == 8'hFF);
endmodule

// File: rtl/mbx_state_irq.sv
module mbx_state_irq
  import mbx_pkg::*;
#(
  parameter int            N_CHAN          = 7,
  parameter logic [15:0]   TX_STATE_BASE   = 16'h0300,
  parameter logic [15:0]   RX_STATE_BASE   = 16'h0308,
  parameter logic [15:0]   ALIVE_ADDR      = 16'h0310
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cp_we_i,
  input  logic [15:0]       cp_addr_i,
  input  logic [7:0]        cp_wdata_i,
  input  logic              host_we_i,
  input  logic [15:0]       host_addr_i,
  input  logic [7:0]        host_wdata_i,
  input  logic              int0_clr_i,
  input  logic              int1_clr_i,
  output logic              int0_o,
  output logic              int1_o,
  output logic [N_CHAN-1:0] tx_done_map_o,
  output logic [N_CHAN-1:0] rx_new_map_o,
  output logic              alive_o
);
  snoop_t cp_w, host_w;
  logic   tx_hit, rx_hit;

  assign cp_w   = '{we: cp_we_i,   addr: cp_addr_i,   data: cp_wdata_i};
  assign host_w = '{we: host_we_i, addr: host_addr_i, data: host_wdata_i};

  mbx_chan_tracker #(
    .N_CHAN(N_CHAN), .BASE(TX_STATE_BASE), .MATCH(ST_COMPLETE)
  ) u_tx (
    .clk_i, .rst_ni, .cp_i(cp_w), .host_i(host_w),
    .map_o(tx_done_map_o), .hit_o(tx_hit)
  );

  mbx_chan_tracker #(
    .N_CHAN(N_CHAN), .BASE(RX_STATE_BASE), .MATCH(ST_NEW)
  ) u_rx (
    .clk_i, .rst_ni, .cp_i(cp_w), .host_i(host_w),
    .map_o(rx_new_map_o), .hit_o(rx_hit)
  );

  mbx_flag u_int0 (.clk_i, .rst_ni, .set_i(tx_hit), .clr_i(int0_clr_i), .flag_o(int0_o));
  mbx_flag u_int1 (.clk_i, .rst_ni, .set_i(rx_hit), .clr_i(int1_clr_i), .flag_o(int1_o));

  mbx_alive #(.ADDR(ALIVE_ADDR)) u_alive (
    .clk_i, .rst_ni, .cp_i(cp_w), .host_i(host_w), .alive_o
  );
endmodule

// File: rtl/mbx_state_irq_chk.sv
module mbx_state_irq_chk #(
  parameter int          N_CHAN        = 7,
  parameter logic [15:0] TX_STATE_BASE = 16'h0300,
  parameter logic [15:0] RX_STATE_BASE = 16'h0308,
  parameter logic [15:0] ALIVE_ADDR    = 16'h0310
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        cp_we_i,
  input logic [15:0] cp_addr_i,
  input logic [7:0]  cp_wdata_i,
  input logic        host_we_i,
  input logic [15:0] host_addr_i,
  input logic [7:0]  host_wdata_i,
  input logic        int0_clr_i,
  input logic        int1_clr_i,
  input logic        int0_o,
  input logic        int1_o,
  input logic        alive_o
);
  localparam logic [15:0] TxEnd = TX_STATE_BASE + 16'(N_CHAN);
  localparam logic [15:0] RxEnd = RX_STATE_BASE + 16'(N_CHAN);

  p_tx_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_we_i && cp_addr_i >= TX_STATE_BASE && cp_addr_i < TxEnd && cp_wdata_i == 8'h03
    |=> int0_o);

  p_rx_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cp_we_i && cp_addr_i >= RX_STATE_BASE && cp_addr_i < RxEnd && cp_wdata_i == 8'h01
    |=> int1_o);

  p_host_no_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cp_we_i && !int0_o && !int1_o |=> !int0_o && !int1_o);

  p_sticky0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int0_o && !int0_clr_i |=> int0_o);

  p_sticky1_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int1_o && !int1_clr_i |=> int1_o);

  p_alive_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i && host_addr_i == ALIVE_ADDR && host_wdata_i == 8'h00
    && !(cp_we_i && cp_addr_i == ALIVE_ADDR) |=> !alive_o);
endmodule

bind mbx_state_irq mbx_state_irq_chk #(
  .N_CHAN(N_CHAN), .TX_STATE_BASE(TX_STATE_BASE),
  .RX_STATE_BASE(RX_STATE_BASE), .ALIVE_ADDR(ALIVE_ADDR)
) u_chk (
  .clk_i, .rst_ni, .cp_we_i, .cp_addr_i, .cp_wdata_i,
  .host_we_i, .host_addr_i, .host_wdata_i, .int0_clr_i, .int1_clr_i,
  .int0_o, .int1_o, .alive_o
);

// File: tb/mbx_state_irq_bench.sv
`timescale 1ns/1ps
module mbx_state_irq_bench;
  localparam int          NC     = 7;
  localparam logic [15:0] TXS    = 16'h0300;
  localparam logic [15:0] RXS    = 16'h0308;
  localparam logic [15:0] ALV    = 16'h0310;
  localparam logic [15:0] TXMSG  = 16'h0100;
  localparam logic [15:0] RXMSG  = 16'h0200;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cp_we = 0, host_we = 0, clr0 = 0, clr1 = 0;
  logic [15:0] cp_addr = '0, host_addr = '0;
  logic [7:0]  cp_data = '0, host_data = '0;
  logic int0, int1, alive;
  logic [NC-1:0] tx_map, rx_map;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] m_tx [NC];
  logic [7:0] m_rx [NC];
  logic [7:0] m_alive;
  logic m_int0, m_int1;

  always #2.5 clk = ~clk;

  mbx_state_irq u_mbx_state_irq (
    .clk_i(clk), .rst_ni(rst_n),
    .cp_we_i(cp_we), .cp_addr_i(cp_addr), .cp_wdata_i(cp_data),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_data),
    .int0_clr_i(clr0), .int1_clr_i(clr1),
    .int0_o(int0), .int1_o(int1),
    .tx_done_map_o(tx_map), .rx_new_map_o(rx_map), .alive_o(alive)
  );

  task automatic check(input string tag);
    logic [NC-1:0] etx, erx;
    logic [NC+NC+2:0] act, exp;
    for (int i = 0; i < NC; i++) begin
      etx[i] = (m_tx[i] == 8'h03);
      erx[i] = (m_rx[i] == 8'h01);
    end
    act = {tx_map, rx_map, int0, int1, alive};
    exp = {etx, erx, m_int0, m_int1, (m_alive == 8'hFF)};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {txmap,rxmap,int0,int1,alive} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, model update, sample after the edge
  task automatic cyc(input logic cwe, input logic [15:0] ca, input logic [7:0] cd,
                     input logic hwe, input logic [15:0] ha, input logic [7:0] hd,
                     input logic c0, input logic c1, input string tag);
    logic s0, s1;
    @(negedge clk);
    cp_we = cwe; cp_addr = ca; cp_data = cd;
    host_we = hwe; host_addr = ha; host_data = hd;
    clr0 = c0; clr1 = c1;
    s0 = 0; s1 = 0;
    for (int i = 0; i < NC; i++) begin
      if (cwe && ca == TXS + 16'(i)) begin m_tx[i] = cd; if (cd == 8'h03) s0 = 1; end
      else if (hwe && ha == TXS + 16'(i)) m_tx[i] = hd;
      if (cwe && ca == RXS + 16'(i)) begin m_rx[i] = cd; if (cd == 8'h01) s1 = 1; end
      else if (hwe && ha == RXS + 16'(i)) m_rx[i] = hd;
    end
    if (cwe && ca == ALV) m_alive = cd;
    else if (hwe && ha == ALV) m_alive = hd;
    m_int0 = s0 | (m_int0 & ~c0);
    m_int1 = s1 | (m_int1 & ~c1);
    @(negedge clk);
    cp_we = 0; host_we = 0; clr0 = 0; clr1 = 0;
    check(tag);
  endtask

  initial begin
    for (int i = 0; i < NC; i++) begin m_tx[i] = 0; m_rx[i] = 0; end
    m_alive = 0; m_int0 = 0; m_int1 = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rst_n = 1;
    @(negedge clk);
    check("R1");

    // host sweep: bitmaps follow, flags never set (R6); ch 7 is out of range (R10)
    for (int d = 0; d < 2; d++)
      for (int ch = 0; ch <= NC; ch++)
        for (int v = 0; v < 4; v++)
          cyc(0, '0, '0, 1, (d == 0 ? TXS : RXS) + 16'(ch), 8'(v), 0, 0,
              d == 0 ? "R2/R6" : "R3/R6");

    // coprocessor sweep, flags cleared after each step
    for (int d = 0; d < 2; d++)
      for (int ch = 0; ch <= NC; ch++)
        for (int v = 0; v < 4; v++) begin
          cyc(1, (d == 0 ? TXS : RXS) + 16'(ch), 8'(v), 0, '0, '0, 0, 0,
              d == 0 ? "R4" : "R5");
          cyc(0, '0, '0, 0, '0, '0, 1, 1, "R7 clear");
        end

    // sticky flags across further changes
    cyc(1, TXS + 2, 8'h03, 0, '0, '0, 0, 0, "R4");
    cyc(0, '0, '0, 1, TXS + 2, 8'h00, 0, 0, "R7 sticky host idle");
    cyc(1, TXS + 5, 8'h02, 0, '0, '0, 0, 0, "R7 sticky cp rcvd");
    cyc(1, RXS + 6, 8'h01, 0, '0, '0, 0, 0, "R5");
    cyc(1, TXS + 6, 8'h03, 0, '0, '0, 1, 0, "R7 set beats clear");
    cyc(1, RXS + 0, 8'h01, 0, '0, '0, 0, 1, "R7 set beats clear");
    cyc(0, '0, '0, 0, '0, '0, 1, 0, "R7 clear int0 only");
    cyc(0, '0, '0, 0, '0, '0, 0, 1, "R7 clear int1 only");

    // same-byte collisions
    for (int ch = 0; ch < NC; ch++) begin
      cyc(1, TXS + 16'(ch), 8'h03, 1, TXS + 16'(ch), 8'h01, 1, 1, "R9 tx");
      cyc(1, RXS + 16'(ch), 8'h02, 1, RXS + 16'(ch), 8'h01, 1, 1, "R9 rx");
    end
    cyc(1, ALV, 8'hFF, 1, ALV, 8'h00, 0, 0, "R9 alive");
    cyc(1, ALV, 8'h00, 1, ALV, 8'hFF, 0, 0, "R9 alive");

    // message-slot writes with state-like values
    for (int ch = 0; ch < NC; ch++) begin
      cyc(1, TXMSG + 16'(ch * 32), 8'h03, 1, RXMSG + 16'(ch * 32), 8'h01, 0, 0, "R10");
      cyc(1, RXMSG + 16'(ch * 32), 8'h01, 1, ALV + 1, 8'hFF, 0, 0, "R10");
    end

    // liveness byte
    cyc(1, ALV, 8'hFF, 0, '0, '0, 0, 0, "R8 cp alive");
    cyc(0, '0, '0, 1, ALV, 8'h00, 0, 0, "R8 host clear");
    cyc(1, ALV, 8'hFE, 0, '0, '0, 0, 0, "R8 not ff");
    cyc(0, '0, '0, 1, ALV, 8'hFF, 0, 0, "R8 host ff");
    cyc(1, ALV, 8'h7F, 0, '0, '0, 0, 0, "R8 cp overwrite");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule